// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the command-level controller for sequential two-byte programming in a serial flash. It sits behind a command decoder that has already assembled each SPI transaction into one strobe carrying the opcode, a 24-bit address and two data bytes. The decoder also passes on the chip-select level. The sequencer owns the write-enable latch and the sequential-programming status bit. It also holds a pointer to the next word and a self-timed program timer. Each word it programs appears as two byte-write requests on an abstract memory port.

A sequence starts with one command that carries an address. After that, each continuation command carries only two data bytes and programs the next word. While the sequence is active, only a few commands are obeyed. The sequence ends on a write-disable, or when the next word would lie at or beyond the protection boundary or the top of the array. The host can also choose to see busy/ready directly on the serial-output pin while chip select is low, so it does not have to poll the status register.

Top module: `aai_word_seq`

## Requirements
- R1: After reset, `aai_bit`, `wel_bit`, `busy`, `wr_en` and `so_oe` are all 0, and ready/busy output is disabled.
- R2: Every command acts at the first chip-select rising edge after its strobe. Outside a sequence and while idle, opcode 06h sets `wel_bit` and opcode 04h clears it.
- R3: A start command (opcode ADh) accepted outside a sequence writes `cmd_d0` to the even address `{A[ADDR_W-1:1],0}` in the first cycle after the chip-select rise. It writes `cmd_d1` to that address with bit 0 set in the next cycle. Address bits at and above ADDR_W are ignored, and `aai_bit` becomes 1.
- R4: `busy` rises in the cycle after the launching chip-select rise and stays high for exactly PROG_CYCLES cycles.
- R5: Inside a sequence, each ADh command ignores its address field and programs the two addresses that follow the previous word.
- R6: A start command is ignored when `wel_bit` is 0, or when the odd address of the target word is at or above `prot_base`. Ignored means no write, no busy, and no change to `aai_bit` or `wel_bit`.
- R7: Inside a sequence, every opcode other than ADh, 05h and 04h has no effect. For example, 80h leaves ready/busy output enabled.
- R8: Opcode 04h inside a sequence clears `aai_bit` and `wel_bit` at once. A word program already running still writes both bytes and keeps `busy` high for its full length.
- R9: An ADh command that executes while `busy` is high is dropped. Nothing is written, and the pointer does not advance.
- R10: There is no wrap-around. When a launched word's next address is at or above `prot_base` (`prot_base` = 2^ADDR_W means the top of the array), `aai_bit` and `wel_bit` clear in the cycle after launch, and later ADh commands are ignored.
- R11: After opcode 70h, while chip select is low and either a sequence is active or `busy` is high, `so_oe` is 1 and `so_val` is 0 when busy and 1 when ready. With chip select high, `so_oe` is 0.
- R12: Opcode 80h disables ready/busy output only outside a sequence. After it, `so_oe` stays 0 during a later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select level, active low |
| cmd_valid | input | 1 | One-cycle strobe: a complete command has been received |
| cmd_op | input | 8 | Opcode of the received command |
| cmd_addr | input | 24 | Address field of the command |
| cmd_d0 | input | 8 | First data byte |
| cmd_d1 | input | 8 | Second data byte |
| prot_base | input | ADDR_W+1 | Lowest protected byte address; 2^ADDR_W means none protected |
| wr_en | output | 1 | Byte-write request to the memory port |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte to program |
| aai_bit | output | 1 | Sequential programming active |
| wel_bit | output | 1 | Write-enable latch |
| busy | output | 1 | Word program in progress |
| so_oe | output | 1 | Serial output driven with ready/busy |
| so_val | output | 1 | Ready/busy level: 1 ready, 0 busy |

## Verification
The hardest condition to reach is a continuation command that executes while a word is still programming. It must be dropped without moving the pointer. The bench sets PROG_CYCLES longer than one full command transaction and sends a second command straight after a launch, then shows that the next accepted word lands on the address the dropped one would have used. The exit at the protection boundary or the array top is the other hard case. With a 6-bit address space, the bench runs a chain from every even start address up to two different boundaries. It checks every byte written and the moment `aai_bit` drops.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

    localparam int CMD_ADDR_W = 24;
    localparam int BYTE_W     = 8;

    localparam logic [BYTE_W-1:0] OP_SEQ_PROG = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_STATUS   = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_DIS   = 8'h04;
    localparam logic [BYTE_W-1:0] OP_WR_EN    = 8'h06;
    localparam logic [BYTE_W-1:0] OP_RB_ON    = 8'h70;
    localparam logic [BYTE_W-1:0] OP_RB_OFF   = 8'h80;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WREN,
        ACT_WRDI,
        ACT_RB_ON,
        ACT_RB_OFF,
        ACT_PROG
    } act_e;

endpackage

// File: rtl/aai_cs_edge.sv
module aai_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_rise,
    output logic cs_fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign cs_rise = cs_n & ~prev_q;
    assign cs_fall = ~cs_n & prev_q;
endmodule

// File: rtl/aai_op_filter.sv
module aai_op_filter
    import aai_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    input  logic              seq_active,
    input  logic              prog_busy,
    output act_e              act
);
    always_comb begin
        act = ACT_NONE;
        if (prog_busy) begin
            // while programming only the write-disable has an effect
            if (op == OP_WR_DIS) act = ACT_WRDI;
        end else if (seq_active) begin
            unique case (op)
                OP_SEQ_PROG: act = ACT_PROG;
                OP_WR_DIS:   act = ACT_WRDI;
                default:     act = ACT_NONE;
            endcase
        end else begin
            unique case (op)
                OP_SEQ_PROG: act = ACT_PROG;
                OP_WR_EN:    act = ACT_WREN;
                OP_WR_DIS:   act = ACT_WRDI;
                OP_RB_ON:    act = ACT_RB_ON;
                OP_RB_OFF:   act = ACT_RB_OFF;
                default:     act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic slot_lo,
    output logic slot_hi
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] CNT_NEXT = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CNT_FULL;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy    = (cnt_q != '0);
    assign slot_lo = (cnt_q == CNT_FULL);
    assign slot_hi = (cnt_q == CNT_NEXT);
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  cmd_valid,
    input  logic [BYTE_W-1:0]     cmd_op,
    input  logic [CMD_ADDR_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0]     cmd_d0,
    input  logic [BYTE_W-1:0]     cmd_d1,
    input  logic [ADDR_W:0]       prot_base,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  aai_bit,
    output logic                  wel_bit,
    output logic                  busy,
    output logic                  so_oe,
    output logic                  so_val
);
    localparam int WORD_W = ADDR_W - 1;

    typedef struct packed {
        logic              aai;
        logic              wel;
        logic              rb_en;
        logic              pend;
        logic [BYTE_W-1:0] pop;
        logic [WORD_W-1:0] pword;
        logic [BYTE_W-1:0] pd0;
        logic [BYTE_W-1:0] pd1;
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] wword;
        logic [BYTE_W-1:0] wd0;
        logic [BYTE_W-1:0] wd1;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic cs_rise, cs_fall;
    logic launch;
    logic slot_lo, slot_hi;
    act_e act;

    logic [WORD_W-1:0] base_w;
    logic [WORD_W:0]   next_x;
    logic [ADDR_W:0]   hi_byte_x;
    logic [ADDR_W:0]   next_byte_x;
    logic              in_range;
    logic              at_end;
    logic              addr_bits_unused;

    assign addr_bits_unused = ^cmd_addr;

    aai_cs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall)
    );

    aai_op_filter u_filter (
        .op         (st_q.pop),
        .seq_active (st_q.aai),
        .prog_busy  (busy),
        .act        (act)
    );

    aai_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch),
        .busy    (busy),
        .slot_lo (slot_lo),
        .slot_hi (slot_hi)
    );

    // target word, its upper byte and the word that follows
    always_comb begin
        base_w      = st_q.aai ? st_q.ptr : st_q.pword;
        hi_byte_x   = {1'b0, base_w, 1'b1};
        next_x      = {1'b0, base_w} + 1'b1;
        next_byte_x = {next_x, 1'b0};
        in_range    = (hi_byte_x < prot_base);
        at_end      = (next_byte_x >= prot_base);
    end

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;

        if (cs_fall) st_d.pend = 1'b0;

        if (cs_rise && st_q.pend) begin
            st_d.pend = 1'b0;
            unique case (act)
                ACT_WREN:   st_d.wel = 1'b1;
                ACT_WRDI: begin
                    st_d.wel = 1'b0;
                    st_d.aai = 1'b0;
                end
                ACT_RB_ON:  st_d.rb_en = 1'b1;
                ACT_RB_OFF: st_d.rb_en = 1'b0;
                ACT_PROG: begin
                    if (st_q.wel && in_range) begin
                        launch     = 1'b1;
                        st_d.wword = base_w;
                        st_d.wd0   = st_q.pd0;
                        st_d.wd1   = st_q.pd1;
                        if (at_end) begin
                            st_d.aai = 1'b0;
                            st_d.wel = 1'b0;
                        end else begin
                            st_d.aai = 1'b1;
                            st_d.ptr = next_x[WORD_W-1:0];
                        end
                    end else if (st_q.aai) begin
                        // pointer fell into a protected area
                        st_d.aai = 1'b0;
                        st_d.wel = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (cmd_valid) begin
            st_d.pend  = 1'b1;
            st_d.pop   = cmd_op;
            st_d.pword = cmd_addr[ADDR_W-1:1];
            st_d.pd0   = cmd_d0;
            st_d.pd1   = cmd_d1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = slot_lo | slot_hi;
    assign wr_addr = {st_q.wword, slot_hi};
    assign wr_data = slot_hi ? st_q.wd1 : st_q.wd0;
    assign aai_bit = st_q.aai;
    assign wel_bit = st_q.wel;
    assign so_oe   = st_q.rb_en & (st_q.aai | busy) & ~cs_n;
    assign so_val  = ~busy;
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk #(
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              aai_bit,
    input logic              wel_bit,
    input logic              busy,
    input logic              so_oe,
    input logic              so_val
);
    localparam int RUN_W = $clog2(PROG_CYCLES + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R3

    AST_BYTE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[0]) |=> (wr_en && wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R3

    AST_BUSY_OPENS_WITH_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wr_en && !wr_addr[0])); // R4

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != '0) |-> (run_q == RUN_W'(PROG_CYCLES))); // R4

    AST_SEQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        aai_bit |-> wel_bit); // R8

    AST_SO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe); // R11

    AST_SO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (so_val == !busy)); // R11
endmodule

bind aai_word_seq aai_word_seq_chk #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .aai_bit (aai_bit),
    .wel_bit (wel_bit),
    .busy    (busy),
    .so_oe   (so_oe),
    .so_val  (so_val)
);

// File: tb/aai_word_seq_tb.sv
module aai_word_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int PC         = 8;
    localparam int DEPTH      = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_op = '0;
    logic [23:0]     cmd_addr = '0;
    logic [7:0]      cmd_d0 = '0;
    logic [7:0]      cmd_d1 = '0;
    logic [AW:0]     prot_base = (AW+1)'(DEPTH);
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;
    logic            aai_bit, wel_bit, busy, so_oe, so_val;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    bit finished = 1'b0;
    logic [7:0] shadow [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    aai_word_seq #(.ADDR_W(AW), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_d0(cmd_d0), .cmd_d1(cmd_d1),
        .prot_base(prot_base), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .aai_bit(aai_bit), .wel_bit(wel_bit), .busy(busy), .so_oe(so_oe), .so_val(so_val)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            shadow[wr_addr] <= wr_data;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [23:0] a,
                        input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin
            cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_d0 = b0; cmd_d1 = b1;
        end
        @(negedge clk) cmd_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    function automatic logic [7:0] pat0(input int s, input int w);
        return 8'(((s * 7) + w) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] pat1(input int s, input int w);
        return 8'(((s * 3) + (w * 5)) ^ 8'hC3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bc;
        int wbase;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!aai_bit && !wel_bit, "R1", {aai_bit, wel_bit}, 0);
        chk(!busy && !wr_en, "R1", {busy, wr_en}, 0);
        chk(!so_oe, "R1", so_oe, 0);
        rst_n = 1'b1;

        // R2 write enable / disable
        send(8'h06, 0, 0, 0); @(negedge clk);
        chk(wel_bit == 1'b1, "R2", wel_bit, 1);
        send(8'h04, 0, 0, 0); @(negedge clk);
        chk(wel_bit == 1'b0, "R2", wel_bit, 0);

        // R6 start without write enable
        send(8'hAD, 24'd4, 8'h01, 8'h02); repeat (3) @(negedge clk);
        chk(!busy && !aai_bit && wcount == 0, "R6", wcount, 0);

        // R3 / R4 first word with junk upper address bits
        send(8'h70, 0, 0, 0);
        send(8'h06, 0, 0, 0);
        send(8'hAD, 24'hFFFF11, 8'hA1, 8'hB2);
        @(negedge clk);
        chk(busy && wr_en && wr_addr == 6'd16, "R3", wr_addr, 16);
        chk(wr_data == 8'hA1 && aai_bit, "R3", wr_data, 8'hA1);
        @(negedge clk);
        chk(wr_en && wr_addr == 6'd17 && wr_data == 8'hB2, "R3", wr_addr, 17);
        bc = 2;
        forever begin
            @(negedge clk);
            if (busy) bc++; else break;
        end
        chk(bc == PC, "R4", bc, PC);

        // R9 command during busy is dropped; R11 ready/busy on the pin
        send(8'hAD, 24'd0, 8'hC3, 8'hD4);
        @(negedge clk);
        send(8'hAD, 24'd0, 8'hE5, 8'hF6);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk(so_oe && busy && !so_val, "R11", {so_oe, so_val}, 2);
        while (busy) @(negedge clk);
        chk(so_oe && so_val, "R11", {so_oe, so_val}, 3);
        cs_n = 1'b1;
        @(negedge clk);
        chk(!so_oe, "R11", so_oe, 0);
        chk(wcount == 4 && shadow[18] == 8'hC3 && shadow[19] == 8'hD4, "R5", wcount, 4);
        send(8'hAD, 24'd0, 8'h17, 8'h28);
        wait_idle();
        chk(wcount == 6 && shadow[20] == 8'h17 && shadow[21] == 8'h28, "R9", shadow[20], 8'h17);

        // R7 disable of ready/busy ignored inside the sequence
        send(8'h80, 0, 0, 0);
        send(8'hAD, 24'd0, 8'h33, 8'h44);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk(so_oe == 1'b1, "R7", so_oe, 1);
        cs_n = 1'b1;
        wait_idle();
        chk(shadow[22] == 8'h33 && shadow[23] == 8'h44, "R7", shadow[22], 8'h33);

        // R8 write-disable during a running program
        send(8'hAD, 24'd0, 8'h9A, 8'hBC);
        send(8'h04, 0, 0, 0);
        @(negedge clk);
        chk(!aai_bit && !wel_bit && busy, "R8", {aai_bit, wel_bit, busy}, 1);
        wait_idle();
        chk(wcount == 10 && shadow[24] == 8'h9A && shadow[25] == 8'hBC, "R8", wcount, 10);

        // R12 ready/busy disabled outside the sequence
        send(8'h80, 0, 0, 0);
        send(8'h06, 0, 0, 0);
        send(8'hAD, 24'd30, 8'h11, 8'h22);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk(!so_oe && aai_bit, "R12", so_oe, 0);
        cs_n = 1'b1;
        wait_idle();
        send(8'h04, 0, 0, 0); @(negedge clk);
        chk(!aai_bit, "R12", aai_bit, 0);

        // R10 exit at the protection boundary
        prot_base = 7'd40;
        send(8'h06, 0, 0, 0);
        send(8'hAD, 24'd34, 8'h01, 8'h02); wait_idle();
        send(8'hAD, 24'd0, 8'h03, 8'h04); wait_idle();
        chk(aai_bit, "R10", aai_bit, 1);
        send(8'hAD, 24'd0, 8'h05, 8'h06);
        @(negedge clk);
        chk(!aai_bit && !wel_bit, "R10", {aai_bit, wel_bit}, 0);
        wait_idle();
        chk(shadow[39] == 8'h06, "R10", shadow[39], 6);
        bc = wcount;
        send(8'hAD, 24'd0, 8'h07, 8'h08); repeat (3) @(negedge clk);
        chk(wcount == bc && !busy, "R10", wcount, bc);

        // R6 protected start address
        send(8'h06, 0, 0, 0);
        send(8'hAD, 24'd40, 8'h09, 8'h0A); repeat (3) @(negedge clk);
        chk(!busy && !aai_bit && wel_bit && wcount == bc, "R6", wcount, bc);
        send(8'h04, 0, 0, 0);

        // R10 top of array
        prot_base = 7'd64;
        send(8'h06, 0, 0, 0);
        send(8'hAD, 24'd62, 8'h6E, 8'h7F);
        @(negedge clk);
        chk(!aai_bit && !wel_bit, "R10", aai_bit, 0);
        wait_idle();
        chk(shadow[62] == 8'h6E && shadow[63] == 8'h7F, "R10", shadow[63], 8'h7F);

        // R5 sweep: chains from every even start to two boundaries
        for (int pi = 0; pi < 2; pi++) begin
            int pb;
            pb = (pi == 0) ? 24 : 64;
            prot_base = (AW+1)'(pb);
            for (int s = 0; s < pb - 1; s += 2) begin
                send(8'h06, 0, 0, 0);
                send(8'hAD, {18'h2AAAA, 6'(s)}, pat0(s, s), pat1(s, s));
                wbase = s;
                forever begin
                    wait_idle();
                    chk(shadow[wbase] == pat0(s, wbase), "R5", shadow[wbase], pat0(s, wbase));
                    chk(shadow[wbase+1] == pat1(s, wbase), "R5", shadow[wbase+1], pat1(s, wbase));
                    chk(aai_bit == (wbase + 2 < pb), "R10", aai_bit, (wbase + 2 < pb));
                    if (wbase + 2 >= pb) break;
                    wbase += 2;
                    send(8'hAD, 24'hABCDEF, pat0(s, wbase), pat1(s, wbase));
                end
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule